// File: doc/BRIEF.md
# Peak or Average Sample Reducer

This block reduces a stream of 8-bit vertical samples to one value per horizontal position. A position holds every sample accepted between two accepted start-divide pulses. When the upstream logic sees the horizontal position change, it pulses `div_start`. The block then closes the position and later reports one 8-bit result with a one-cycle strobe. The `mode_peak` input selects the result: the largest sample of the position, or the truncated mean of its samples.

For the mean, the block keeps a running total. Each sample is added into an 8-bit register, and every carry out of that add increments a 17-bit carry counter. Together these two form a 25-bit numerator. A separate 17-bit counter counts the accepted samples and serves as the denominator. When the block accepts `div_start`, it captures the totals and clears the accumulators in the same cycle, so the next position begins from zero. It then finds the highest set bit of the denominator and uses it to place a single 1 in a 25-bit quotient-weight register. Restoring division then produces one quotient bit per clock. Samples that arrive during the division belong to the next position and are kept.

Top module: `peak_avg_reducer`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_y` is 0 until a result is produced.
- R2: With peak mode latched, the result equals the largest `in_y` accepted for the closed position.
- R3: With average mode latched, the result equals floor(sum of accepted samples / number of accepted samples).
- R4: The sum is held in 25 bits: an 8-bit add plus a 17-bit carry counter. Averages remain exact for positions of up to 2^17-1 samples, including counts above 2^16.
- R5: An accepted `div_start` clears the running sum, the sample count and the peak, so no value carries over into the next position.
- R6: Each accepted `div_start` yields exactly one `out_valid` pulse, at most 26 rising edges after the edge that accepted it.
- R7: `mode_peak` is sampled on the edge that accepts `div_start` (1 = peak, 0 = average). Later changes to it do not affect that result.
- R8: A sample valid on the same edge as an accepted `div_start` is counted in the new position, not in the one being closed.
- R9: Samples accepted while a division is running are accumulated into the next position and are not lost.
- R10: A `div_start` that arrives while a division is running is ignored. It produces no result and leaves the accumulators untouched.
- R11: Closing a position that received no samples yields a result of 0 in either mode.
- R12: `in_y` has no effect on any result while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample strobe |
| in_y | input | 8 | Sample value |
| div_start | input | 1 | Closes the current position and starts the reduction |
| mode_peak | input | 1 | 1 selects peak, 0 selects average; sampled with `div_start` |
| out_y | output | 8 | Reduced value of the closed position |
| out_valid | output | 1 | One-cycle strobe marking `out_y` |

## Verification
The sample patterns are chosen so that peak and average give different answers. Short uneven sets check that the mean is truncated rather than rounded. Positions with no samples check the zero-denominator path. A run of 70000 samples near full scale drives the carry counter and the sample count beyond 2^16. Further patterns place samples on the start edge, during the division, and alongside a repeated start pulse. These show whether each sample is assigned to the correct position, and a short pseudo-random series checks both modes against a model in the bench.

// File: rtl/reducer_pkg.sv
package reducer_pkg;
  localparam int SAMPLE_W = 8;
  localparam int COUNT_W  = 17;
endpackage

// File: rtl/reset_sync.sv
module reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/sample_accumulator.sv
module sample_accumulator #(
  parameter int Y_W   = 8,
  parameter int CNT_W = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [Y_W-1:0]       in_y,
  input  logic                 clear,
  output logic [Y_W+CNT_W-1:0] total,
  output logic [CNT_W-1:0]     count,
  output logic [Y_W-1:0]       peak
);
  localparam int TOT_W = Y_W + CNT_W;

  logic [Y_W-1:0]   low_q, low_d, low_base, low_sum;
  logic [CNT_W-1:0] carry_q, carry_d, carry_base;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
  logic [Y_W-1:0]   pk_q, pk_d, pk_base;
  logic             add_carry;
  logic             acc_en;

  always_comb begin
    low_base   = clear ? '0 : low_q;
    carry_base = clear ? '0 : carry_q;
    cnt_base   = clear ? '0 : cnt_q;
    pk_base    = clear ? '0 : pk_q;
    {add_carry, low_sum} = {1'b0, low_base} + {1'b0, in_y};
    low_d   = low_base;
    carry_d = carry_base;
    cnt_d   = cnt_base;
    pk_d    = pk_base;
    if (in_valid) begin
      low_d   = low_sum;
      carry_d = carry_base + CNT_W'(add_carry);
      cnt_d   = cnt_base + CNT_W'(1);
      pk_d    = (in_y > pk_base) ? in_y : pk_base;
    end
    acc_en = clear | in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      carry_q <= '0;
      cnt_q   <= '0;
      pk_q    <= '0;
    end else if (acc_en) begin
      low_q   <= low_d;
      carry_q <= carry_d;
      cnt_q   <= cnt_d;
      pk_q    <= pk_d;
    end
  end

  assign total = {carry_q, low_q};
  assign count = cnt_q;
  assign peak  = pk_q;

  assert_total_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear) |=> total == TOT_W'($past(total) + TOT_W'($past(in_y))));
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear) |=> count == CNT_W'($past(count) + CNT_W'(1)));
  assert_clear_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !in_valid) |=> (count == '0 && total == '0 && peak == '0));
  assert_clear_keeps_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && in_valid) |=> (count == CNT_W'(1) && peak == $past(in_y)));
  assert_peak_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> peak >= $past(peak));
endmodule

// File: rtl/msb_locator.sv
module msb_locator #(
  parameter int W     = 17,
  parameter int IDX_W = 5
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 17,
  parameter int Q_W   = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num_in,
  input  logic [DEN_W-1:0] den_in,
  input  logic [IDX_W-1:0] den_msb,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quotient
);
  logic             busy_q, busy_d, done_q, done_d;
  logic [NUM_W-1:0] rem_q, rem_d, dsh_q, dsh_d, wgt_q, wgt_d, quo_q, quo_d;
  logic [Q_W-1:0]   q_q, q_d;
  logic [IDX_W-1:0] shamt;
  logic             take;
  logic             st_en;
  logic [NUM_W-1:0] quo_next;

  always_comb begin
    shamt    = IDX_W'(NUM_W - 1) - den_msb;
    take     = rem_q >= dsh_q;
    quo_next = take ? (quo_q | wgt_q) : quo_q;
    busy_d = busy_q;
    done_d = 1'b0;
    rem_d  = rem_q;
    dsh_d  = dsh_q;
    wgt_d  = wgt_q;
    quo_d  = quo_q;
    q_d    = q_q;
    if (busy_q) begin
      rem_d = take ? (rem_q - dsh_q) : rem_q;
      quo_d = quo_next;
      dsh_d = dsh_q >> 1;
      wgt_d = wgt_q >> 1;
      if (wgt_q[0]) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        q_d    = (|quo_next[NUM_W-1:Q_W]) ? {Q_W{1'b1}} : quo_next[Q_W-1:0];
      end
    end else if (start) begin
      if (|den_in) begin
        busy_d = 1'b1;
        rem_d  = num_in;
        dsh_d  = NUM_W'(den_in) << shamt;
        wgt_d  = NUM_W'(1) << shamt;
        quo_d  = '0;
      end else begin
        done_d = 1'b1;
        q_d    = '0;
      end
    end
    st_en = busy_q | start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dsh_q <= '0;
      wgt_q <= '0;
      quo_q <= '0;
      q_q   <= '0;
    end else if (st_en) begin
      rem_q <= rem_d;
      dsh_q <= dsh_d;
      wgt_q <= wgt_d;
      quo_q <= quo_d;
      q_q   <= q_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = q_q;

  logic [5:0] steps_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      steps_q <= '0;
    else if (busy_q) steps_q <= steps_q + 6'd1;
    else             steps_q <= '0;
  end

  assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (32'(steps_q) < NUM_W));
  assert_weight_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ($onehot0(wgt_q) && wgt_q != '0));
  assert_remainder_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, rem_q} < {dsh_q, 1'b0}));
endmodule

// File: rtl/peak_avg_reducer.sv
module peak_avg_reducer
  import reducer_pkg::*;
#(
  parameter int Y_W   = SAMPLE_W,
  parameter int CNT_W = COUNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [Y_W-1:0] in_y,
  input  logic           div_start,
  input  logic           mode_peak,
  output logic [Y_W-1:0] out_y,
  output logic           out_valid
);
  localparam int TOT_W = Y_W + CNT_W;
  localparam int IDX_W = $clog2(TOT_W);

  logic             srst_n;
  logic             accept;
  logic             div_busy, div_done;
  logic [TOT_W-1:0] acc_total;
  logic [CNT_W-1:0] acc_count;
  logic [Y_W-1:0]   acc_peak, div_q;
  logic [IDX_W-1:0] msb_idx;
  logic             mode_q, mode_d;
  logic [Y_W-1:0]   pk_q, pk_d;
  logic [Y_W-1:0]   out_q, out_d;
  logic             valid_q;

  reset_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign accept = div_start & ~div_busy;

  sample_accumulator #(.Y_W(Y_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(srst_n), .in_valid(in_valid), .in_y(in_y),
    .clear(accept), .total(acc_total), .count(acc_count), .peak(acc_peak)
  );

  msb_locator #(.W(CNT_W), .IDX_W(IDX_W)) u_msb (.vec(acc_count), .idx(msb_idx));

  restoring_divider #(.NUM_W(TOT_W), .DEN_W(CNT_W), .Q_W(Y_W), .IDX_W(IDX_W)) u_div (
    .clk(clk), .rst_n(srst_n), .start(accept), .num_in(acc_total),
    .den_in(acc_count), .den_msb(msb_idx), .busy(div_busy), .done(div_done),
    .quotient(div_q)
  );

  always_comb begin
    mode_d = accept ? mode_peak : mode_q;
    pk_d   = accept ? acc_peak  : pk_q;
    out_d  = mode_q ? pk_q : div_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q <= 1'b0;
      pk_q   <= '0;
    end else if (accept) begin
      mode_q <= mode_d;
      pk_q   <= pk_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       out_q <= '0;
    else if (div_done) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) valid_q <= 1'b0;
    else         valid_q <= div_done;
  end

  assign out_y     = out_q;
  assign out_valid = valid_q;

  assert_mode_held_R7: assert property (@(posedge clk) disable iff (!srst_n)
    !accept |=> $stable(mode_q));
  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (div_start && div_busy) |=> $stable(pk_q));
  assert_out_stable_R6: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(div_done) |-> $stable(out_y));
endmodule

// File: tb/tb_peak_avg_reducer.sv
module tb_peak_avg_reducer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, div_start, mode_peak;
  logic [7:0] in_y, out_y;
  logic       out_valid;

  peak_avg_reducer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_y(in_y),
    .div_start(div_start), .mode_peak(mode_peak), .out_y(out_y), .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int unsigned n_checks = 0, n_fail = 0;
  int unsigned cyc = 0, start_cyc = 0;
  int unsigned pushed = 0, popped = 0;
  int unsigned m_sum = 0, m_cnt = 0, m_max = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected result", int'(out_y), -1);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_y == e, t, int'(out_y), int'(e));
        check((cyc - start_cyc) <= 26, "R6 latency", int'(cyc - start_cyc), 26);
        popped++;
      end
    end
  end

  task automatic put(input logic [7:0] y);
    in_valid = 1'b1;
    in_y = y;
    m_sum += y;
    m_cnt++;
    if (y > m_max) m_max = y;
    @(negedge clk);
    in_valid = 1'b0;
    in_y = 8'hFF; // R12: junk while invalid
  endtask

  function automatic logic [7:0] expected(input bit pk);
    if (pk) return 8'(m_max);
    if (m_cnt == 0) return 8'd0;
    return 8'(m_sum / m_cnt);
  endfunction

  // Pulses start; optional same-edge sample (R8). Does not wait.
  task automatic close_nw(input bit pk, input string tag, input bit with_y, input logic [7:0] y);
    div_start = 1'b1;
    mode_peak = pk;
    exp_q.push_back(expected(pk));
    tag_q.push_back(tag);
    pushed++;
    m_sum = 0; m_cnt = 0; m_max = 0;
    if (with_y) begin
      in_valid = 1'b1; in_y = y;
      m_sum = y; m_cnt = 1; m_max = y;
    end
    start_cyc = cyc;
    @(negedge clk);
    div_start = 1'b0;
    in_valid = 1'b0;
    mode_peak = ~pk; // R7: change after acceptance
  endtask

  task automatic wait_done();
    while (popped < pushed) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic close(input bit pk, input string tag);
    close_nw(pk, tag, 1'b0, 8'd0);
    wait_done();
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_y = 8'd0; div_start = 1'b0; mode_peak = 1'b0;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    check(out_y == 8'd0, "R1 value in reset", int'(out_y), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    check(out_y == 8'd0, "R1 value after reset", int'(out_y), 0);

    close(1'b0, "R11 empty average");
    close(1'b1, "R11 empty peak");

    put(8'd1); repeat (3) @(negedge clk); put(8'd1); put(8'd2);
    close(1'b0, "R3 truncated mean with R12 idle junk");

    put(8'd10); put(8'd200); put(8'd37); put(8'd199);
    close(1'b1, "R2 peak with R7 late mode change");

    put(8'd4); put(8'd6);
    close(1'b0, "R5 no carry-over average");

    put(8'd50); put(8'd60);
    close_nw(1'b0, "R8 old position excludes start-edge sample", 1'b1, 8'd250);
    wait_done();
    put(8'd10);
    close(1'b1, "R8 start-edge sample in new position");

    put(8'd8); put(8'd8);
    close_nw(1'b0, "R9 position before overlap", 1'b0, 8'd0);
    put(8'd100); put(8'd0); put(8'd200);
    wait_done();
    close(1'b0, "R9 samples during division kept");

    put(8'd3); put(8'd5);
    close_nw(1'b0, "R10 first start", 1'b0, 8'd0);
    put(8'd70);
    div_start = 1'b1; @(negedge clk); div_start = 1'b0; // ignored while busy
    put(8'd20);
    wait_done();
    close(1'b0, "R10 repeated start ignored");

    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int p = 0; p < 6; p++) begin
        for (int k = 0; k < 2 + p * 7; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          put(lfsr[7:0]);
        end
        close(p[0], p[0] ? "R2 pseudo-random peak" : "R3 pseudo-random average");
      end
    end

    for (int i = 0; i < 70000; i++) put(i[0] ? 8'd255 : 8'd254);
    close(1'b0, "R4 long position beyond 2^16 samples");

    finished = 1;
    check(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "R6 watchdog expired", int'(cyc), WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule